// File: doc/BRIEF.md
# Pointer-Addressed I2C Register Slave

This block is an I2C target that gives a bus controller access to the register set of a temperature monitor. The controller writes a pointer byte to pick one of four registers, then either sends data bytes in the same write transaction or reads the selected register in a later transaction. The pointer keeps its value across transactions, so the controller can poll one register again and again without writing the pointer each time. Each register has a fixed read length, and the pointer never advances by itself.

SCL and SDA are oversampled in the system clock domain. SDA is modelled as an input plus an output and an output enable for an open-drain pad: when `sda_oe_o` is high the pad pulls the line to `sda_o`, which is always low. The sensor side feeds the live temperature word in on a parallel input. The stored configuration and limit registers are driven out in parallel. A one-cycle strobe marks every completed register read so that alert logic beside the block can react to it.

Top module: `i2c_ptr_slave`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits equal `{BASE_ADDR, addr_pins_i}` (BASE_ADDR defaults to 4'b1001). It pulls SDA low in the ninth clock after that address byte, after the pointer byte and after every written data byte. Any other address gets no acknowledge, and the rest of that transaction is ignored.
- R2: The first byte after a matching write address loads the pointer. The pointer keeps its value across STOP and repeated START, so reads that follow return the same register without a new pointer write.
- R3: Pointer values select registers: 0 is temperature (read-only), 1 is configuration, 2 is the hysteresis limit and 3 is the overtemperature limit. Data bytes written with pointer 0 or with a pointer above 3 are acknowledged, but no register changes.
- R4: Configuration takes one data byte, which is stored when that byte completes. Further data bytes in the same transaction are acknowledged and ignored.
- R5: A limit register takes two data bytes, most significant byte first, and is updated only when the second byte completes. A transaction with only one data byte leaves the register unchanged.
- R6: A read with pointer 1 returns exactly one byte (the configuration). After the controller's acknowledge bit, the block leaves SDA released until the next START.
- R7: A read with pointer 0, 2 or 3 returns two bytes, MSB first. The value is captured when the read address byte completes. A read with a pointer above 3 returns 16'h0000.
- R8: `rd_strobe_o` is high for exactly one cycle in the ninth clock of the last byte of every register read. If the controller NACKs the first byte of a two-byte read, no strobe is produced.
- R9: A STOP or a repeated START abandons any partly received byte: no register changes, and SDA is released.
- R10: After reset, `cfg_o`, `hyst_o` and `os_o` equal CFG_RESET, HYST_RESET and OS_RESET. The pointer is 0, SDA is released and the strobe is low.
- R11: `sda_oe_o` changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line |
| sda_i | input | 1 | I2C data line as seen at the pad |
| sda_o | output | 1 | Value driven onto SDA when enabled (always 0) |
| sda_oe_o | output | 1 | SDA output enable, high pulls the line low |
| addr_pins_i | input | 3 | Pin-strapped low address bits |
| temp_i | input | 16 | Live temperature word from the sensor |
| cfg_o | output | 8 | Configuration register |
| hyst_o | output | 16 | Hysteresis limit register |
| os_o | output | 16 | Overtemperature limit register |
| rd_strobe_o | output | 1 | One-cycle pulse at each completed register read |

## Verification
The bench builds the block with SYNC_STAGES=3 and a configuration reset value of 8'h18, so the reset check cannot pass on an all-zero register. The deeper synchroniser adds a cycle of latency on every SCL edge, which checks that the SDA hand-over still lands while SCL is low. With address pins 3'b101, a wrong value in the strapped bits and a wrong value in the fixed upper bits can each be tested on its own. The live temperature input is changed between reads to check the capture point and the persistence of the pointer.

// File: rtl/i2c_ptr_pkg.sv
package i2c_ptr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_RX_ACK, ST_TX, ST_TX_ACK, ST_SKIP
  } state_e;

  typedef enum logic [1:0] {PH_ADDR, PH_PTR, PH_DATA} phase_e;

  localparam logic [7:0] PTR_TEMP = 8'd0;
  localparam logic [7:0] PTR_CFG  = 8'd1;
  localparam logic [7:0] PTR_HYST = 8'd2;
  localparam logic [7:0] PTR_OS   = 8'd3;
endpackage

// File: rtl/i2c_ptr_sync.sv
module i2c_ptr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_d <= scl_q[STAGES-1];
      sda_d <= sda_q[STAGES-1];
    end
  end

  assign scl_o      = scl_q[STAGES-1];
  assign sda_o      = sda_q[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_d;
  assign scl_fall_o = ~scl_o & scl_d;
  // SDA edges with SCL steady high
  assign start_o    = scl_o & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_o & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/i2c_ptr_regs.sv
module i2c_ptr_regs
  import i2c_ptr_pkg::*;
#(
  parameter logic [7:0]  CFG_RESET  = 8'h00,
  parameter logic [15:0] HYST_RESET = 16'h4B00,
  parameter logic [15:0] OS_RESET   = 16'h5000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_valid_i,
  input  logic [1:0]  wr_idx_i,
  input  logic [7:0]  ptr_i,
  input  logic [7:0]  wr_byte_i,
  input  logic [15:0] temp_i,
  output logic [7:0]  cfg_o,
  output logic [15:0] hyst_o,
  output logic [15:0] os_o,
  output logic [15:0] rd_word_o,
  output logic        rd_single_o
);
  logic [7:0] msb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msb_q  <= '0;
      cfg_o  <= CFG_RESET;
      hyst_o <= HYST_RESET;
      os_o   <= OS_RESET;
    end else if (wr_valid_i) begin
      if (wr_idx_i == 2'd0) msb_q <= wr_byte_i;
      case (ptr_i)
        PTR_CFG:  if (wr_idx_i == 2'd0) cfg_o  <= wr_byte_i;
        PTR_HYST: if (wr_idx_i == 2'd1) hyst_o <= {msb_q, wr_byte_i};
        PTR_OS:   if (wr_idx_i == 2'd1) os_o   <= {msb_q, wr_byte_i};
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_single_o = (ptr_i == PTR_CFG);
    case (ptr_i)
      PTR_TEMP: rd_word_o = temp_i;
      PTR_CFG:  rd_word_o = {cfg_o, 8'h00};
      PTR_HYST: rd_word_o = hyst_o;
      PTR_OS:   rd_word_o = os_o;
      default:  rd_word_o = '0;
    endcase
  end
endmodule

// File: rtl/i2c_ptr_slave.sv
module i2c_ptr_slave
  import i2c_ptr_pkg::*;
#(
  parameter logic [3:0]  BASE_ADDR   = 4'b1001,
  parameter int          SYNC_STAGES = 2,
  parameter logic [7:0]  CFG_RESET   = 8'h00,
  parameter logic [15:0] HYST_RESET  = 16'h4B00,
  parameter logic [15:0] OS_RESET    = 16'h5000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_o,
  output logic        sda_oe_o,
  input  logic [2:0]  addr_pins_i,
  input  logic [15:0] temp_i,
  output logic [7:0]  cfg_o,
  output logic [15:0] hyst_o,
  output logic [15:0] os_o,
  output logic        rd_strobe_o
);
  localparam logic [6:0] DEV_HI = {BASE_ADDR, 3'b000};

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  state_e      state_q;
  phase_e      phase_q;
  logic [3:0]  bit_cnt_q;
  logic [7:0]  sh_q, ptr_q;
  logic [1:0]  idx_q;
  logic        rw_q, tx_single_q, tx_lsb_q, ack_q, oe_q, strobe_q;
  logic [15:0] tx_word_q, rd_word;
  logic        rd_single, byte_end, addr_hit, wr_valid, last_byte;

  i2c_ptr_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall), .start_o(start_det), .stop_o(stop_det)
  );

  assign byte_end  = (state_q == ST_RX) && scl_fall && (bit_cnt_q == 4'd8);
  assign addr_hit  = sh_q[7:1] == (DEV_HI | {4'b0000, addr_pins_i});
  assign wr_valid  = byte_end && (phase_q == PH_DATA);
  assign last_byte = tx_single_q | tx_lsb_q;

  i2c_ptr_regs #(
    .CFG_RESET(CFG_RESET), .HYST_RESET(HYST_RESET), .OS_RESET(OS_RESET)
  ) regs_i (
    .clk_i, .rst_ni,
    .wr_valid_i(wr_valid), .wr_idx_i(idx_q), .ptr_i(ptr_q),
    .wr_byte_i(sh_q), .temp_i,
    .cfg_o, .hyst_o, .os_o,
    .rd_word_o(rd_word), .rd_single_o(rd_single)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      phase_q     <= PH_ADDR;
      bit_cnt_q   <= '0;
      sh_q        <= '0;
      ptr_q       <= PTR_TEMP;
      idx_q       <= '0;
      rw_q        <= 1'b0;
      tx_word_q   <= '0;
      tx_single_q <= 1'b0;
      tx_lsb_q    <= 1'b0;
      ack_q       <= 1'b0;
      oe_q        <= 1'b0;
      strobe_q    <= 1'b0;
    end else begin
      strobe_q <= 1'b0;
      if (stop_det) begin
        state_q <= ST_IDLE;
        oe_q    <= 1'b0;
      end else if (start_det) begin
        state_q   <= ST_RX;
        phase_q   <= PH_ADDR;
        bit_cnt_q <= '0;
        oe_q      <= 1'b0;
      end else begin
        case (state_q)
          ST_RX: begin
            if (scl_rise && bit_cnt_q < 4'd8) begin
              sh_q      <= {sh_q[6:0], sda_s};
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end else if (byte_end) begin
              case (phase_q)
                PH_ADDR: begin
                  if (addr_hit) begin
                    rw_q        <= sh_q[0];
                    oe_q        <= 1'b1;
                    state_q     <= ST_RX_ACK;
                    tx_word_q   <= rd_word;      // snapshot for coherent MSB/LSB
                    tx_single_q <= rd_single;
                  end else begin
                    state_q <= ST_SKIP;
                  end
                end
                PH_PTR: begin
                  ptr_q   <= sh_q;
                  idx_q   <= '0;
                  oe_q    <= 1'b1;
                  state_q <= ST_RX_ACK;
                end
                default: begin
                  if (idx_q != 2'd2) idx_q <= idx_q + 2'd1;
                  oe_q    <= 1'b1;
                  state_q <= ST_RX_ACK;
                end
              endcase
            end
          end
          ST_RX_ACK: begin
            if (scl_fall) begin
              bit_cnt_q <= '0;
              if (phase_q == PH_ADDR && rw_q) begin
                state_q  <= ST_TX;
                sh_q     <= tx_word_q[15:8];
                oe_q     <= ~tx_word_q[15];
                tx_lsb_q <= 1'b0;
              end else begin
                oe_q    <= 1'b0;
                state_q <= ST_RX;
                phase_q <= (phase_q == PH_ADDR) ? PH_PTR : PH_DATA;
              end
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end else if (scl_fall) begin
              if (bit_cnt_q == 4'd8) begin
                oe_q    <= 1'b0;
                state_q <= ST_TX_ACK;
              end else begin
                sh_q <= {sh_q[6:0], 1'b0};
                oe_q <= ~sh_q[6];
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) begin
              ack_q <= ~sda_s;
              if (last_byte) strobe_q <= 1'b1;
            end else if (scl_fall) begin
              if (ack_q && !last_byte) begin
                sh_q      <= tx_word_q[7:0];
                oe_q      <= ~tx_word_q[7];
                tx_lsb_q  <= 1'b1;
                bit_cnt_q <= '0;
                state_q   <= ST_TX;
              end else begin
                state_q <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_o       = 1'b0;
  assign sda_oe_o    = oe_q;
  assign rd_strobe_o = strobe_q;
endmodule

// File: rtl/i2c_ptr_slave_chk.sv
module i2c_ptr_slave_chk
  import i2c_ptr_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        scl_s_i,
  input logic        scl_fall_i,
  input logic        stop_i,
  input logic        sda_oe_i,
  input logic        rd_strobe_i,
  input logic [7:0]  cfg_i,
  input logic [15:0] hyst_i,
  input logic [15:0] os_i,
  input state_e      state_i
);
  assert_oe_rise_scl_low_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_i) |-> !$past(scl_s_i));

  assert_release_on_stop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !sda_oe_i);

  assert_strobe_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_strobe_i |=> !rd_strobe_i);

  assert_cfg_write_on_fall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cfg_i) |-> $past(scl_fall_i));

  assert_limit_write_on_fall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(hyst_i) || !$stable(os_i)) |-> $past(scl_fall_i));

  assert_idle_released_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_IDLE) |-> !sda_oe_i);
endmodule

bind i2c_ptr_slave i2c_ptr_slave_chk chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_s_i(scl_s), .scl_fall_i(scl_fall),
  .stop_i(stop_det), .sda_oe_i(sda_oe_o), .rd_strobe_i(rd_strobe_o),
  .cfg_i(cfg_o), .hyst_i(hyst_o), .os_i(os_o), .state_i(state_q)
);

// File: tb/i2c_ptr_slave_tb_top.sv
module i2c_ptr_slave_tb_top;
  localparam int Q = 10;
  localparam logic [2:0] PINS = 3'b101;
  localparam logic [6:0] DEV = {4'b1001, PINS};

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_o, sda_oe_o, rd_strobe_o;
  logic [15:0] temp_i = 16'h0000;
  logic [7:0]  cfg_o;
  logic [15:0] hyst_o, os_o;
  wire sda_bus = sda_m & (sda_oe_o ? sda_o : 1'b1);

  int total = 0, passed = 0;
  int strobe_cnt = 0, strobe_wide = 0, oe_viol = 0;
  logic strobe_d = 1'b0, oe_d = 1'b0;

  always #5 clk_i = ~clk_i;

  i2c_ptr_slave #(.SYNC_STAGES(3), .CFG_RESET(8'h18)) dut_i (
    .clk_i, .rst_ni, .scl_i(scl_m), .sda_i(sda_bus), .sda_o, .sda_oe_o,
    .addr_pins_i(PINS), .temp_i, .cfg_o, .hyst_o, .os_o, .rd_strobe_o
  );

  always @(posedge clk_i) begin
    if (rd_strobe_o) strobe_cnt++;
    if (rd_strobe_o && strobe_d) strobe_wide++;
    if (sda_oe_o !== oe_d && scl_m) oe_viol++;
    strobe_d <= rd_strobe_o;
    oe_d     <= sda_oe_o;
  end

  task automatic check(string tag, int act, int exp);
    total++;
    if (act == exp) passed++;
    else $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
  endtask

  task automatic wq(int n = 1);
    repeat (n * Q) @(negedge clk_i);
  endtask

  task automatic i2c_start();
    wq(); sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0;
  endtask

  task automatic i2c_stop();
    wq(); sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic send_bits(logic [7:0] b, int n);
    for (int i = 7; i > 7 - n; i--) begin
      wq(); sda_m = b[i]; wq(); scl_m = 1'b1; wq(2); scl_m = 1'b0;
    end
  endtask

  task automatic send_byte(logic [7:0] b, output logic ack);
    send_bits(b, 8);
    wq(); sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); ack = ~sda_bus; wq(); scl_m = 1'b0;
  endtask

  task automatic recv_byte(logic m_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      wq(2); scl_m = 1'b1; wq(); b = {b[6:0], sda_bus}; wq(); scl_m = 1'b0;
    end
    wq(); sda_m = ~m_ack; wq(); scl_m = 1'b1; wq(2); scl_m = 1'b0;
  endtask

  // write transaction: pointer plus n data bytes; returns number of NACKed bytes
  task automatic write_tx(logic [7:0] p, int n, logic [23:0] d, output int nacks);
    logic a;
    nacks = 0;
    i2c_start();
    send_byte({DEV, 1'b0}, a); if (!a) nacks++;
    send_byte(p, a);           if (!a) nacks++;
    for (int i = 0; i < n; i++) begin
      send_byte(d[23 - 8*i -: 8], a); if (!a) nacks++;
    end
    i2c_stop();
  endtask

  task automatic read_tx(int n, output logic [15:0] w);
    logic a;
    logic [7:0] b;
    w = '0;
    i2c_start();
    send_byte({DEV, 1'b1}, a);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, b);
      w = {w[7:0], b};
    end
    i2c_stop();
  endtask

  task automatic t_reset();
    check("R10 cfg reset", cfg_o, 8'h18);
    check("R10 hyst reset", hyst_o, 16'h4B00);
    check("R10 os reset", os_o, 16'h5000);
    check("R10 sda released", sda_oe_o, 0);
    check("R10 strobe low", rd_strobe_o, 0);
  endtask

  task automatic t_addr();
    logic a;
    i2c_start(); send_byte({4'b1001, 3'b100, 1'b0}, a); i2c_stop();
    check("R1 wrong pin bits nack", a, 0);
    i2c_start(); send_byte({4'b0001, PINS, 1'b0}, a); send_byte(8'h01, a); i2c_stop();
    check("R1 wrong base ignored", a, 0);
    check("R1 wrong address no change", cfg_o, 8'h18);
  endtask

  task automatic t_cfg_write();
    int n;
    write_tx(8'h01, 2, {8'h5A, 8'h33, 8'h00}, n);
    check("R1 ack every byte", n, 0);
    check("R4 cfg written, extra ignored", cfg_o, 8'h5A);
  endtask

  task automatic t_limit_write();
    int n;
    logic a;
    logic [15:0] w;
    write_tx(8'h02, 2, {8'h12, 8'h34, 8'h00}, n);
    check("R5 hyst two bytes", hyst_o, 16'h1234);
    write_tx(8'h03, 1, {8'h99, 16'h0}, n);
    check("R5 single byte no update", os_o, 16'h5000);
    i2c_start(); send_byte({DEV, 1'b0}, a); send_byte(8'h03, a);
    send_byte(8'h77, a); send_bits(8'hAB, 4); i2c_stop();
    check("R9 stop aborts partial byte", os_o, 16'h5000);
    check("R9 sda released after stop", sda_oe_o, 0);
    read_tx(2, w);
    check("R7 os read back", w, 16'h5000);
  endtask

  task automatic t_ptr_ignore();
    int n;
    logic [15:0] w;
    write_tx(8'h00, 2, {8'hFF, 8'hFF, 8'h00}, n);
    check("R3 temp write acked", n, 0);
    check("R3 temp write ignored", {cfg_o, hyst_o, os_o}, {8'h5A, 16'h1234, 16'h5000});
    write_tx(8'h09, 2, {8'hAA, 8'hBB, 8'h00}, n);
    check("R3 undefined ptr ignored", {cfg_o, hyst_o, os_o}, {8'h5A, 16'h1234, 16'h5000});
    read_tx(2, w);
    check("R7 undefined ptr reads zero", w, 16'h0000);
  endtask

  task automatic t_cfg_read();
    int n, s0;
    logic [15:0] w;
    write_tx(8'h01, 0, 24'h0, n);
    s0 = strobe_cnt;
    read_tx(1, w);
    check("R6 cfg one byte", w, 16'h005A);
    check("R8 strobe on cfg read", strobe_cnt - s0, 1);
    check("R6 bus released", sda_oe_o, 0);
  endtask

  task automatic t_temp_read();
    int n, s0;
    logic [15:0] w;
    temp_i = 16'hABCD;
    write_tx(8'h00, 0, 24'h0, n);
    s0 = strobe_cnt;
    read_tx(2, w);
    check("R7 temp MSB then LSB", w, 16'hABCD);
    temp_i = 16'h0123;
    read_tx(2, w);
    check("R2 pointer persists", w, 16'h0123);
    check("R8 strobe per read", strobe_cnt - s0, 2);
  endtask

  task automatic t_rep_start();
    logic a;
    logic [7:0] b1, b0;
    i2c_start(); send_byte({DEV, 1'b0}, a); send_byte(8'h02, a);
    i2c_start(); send_byte({DEV, 1'b1}, a);
    recv_byte(1'b1, b1); recv_byte(1'b0, b0); i2c_stop();
    check("R2 repeated start read hyst", {b1, b0}, 16'h1234);
  endtask

  task automatic t_early_nack();
    int n, s0;
    logic a;
    logic [7:0] b;
    write_tx(8'h03, 0, 24'h0, n);
    s0 = strobe_cnt;
    i2c_start(); send_byte({DEV, 1'b1}, a); recv_byte(1'b0, b); i2c_stop();
    check("R7 os MSB", b, 8'h50);
    check("R8 no strobe on early nack", strobe_cnt - s0, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk_i);
    t_reset();
    t_addr();
    t_cfg_write();
    t_limit_write();
    t_ptr_ignore();
    t_cfg_read();
    t_temp_read();
    t_rep_start();
    t_early_nack();
    check("R11 oe changes only with scl low", oe_viol, 0);
    check("R8 strobe single cycle", strobe_wide, 0);
    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end
endmodule